// File: doc/BRIEF.md
# Three-Wire Serial Word-Store EEPROM Model

This block is a synthesizable behavioural model of a serial EEPROM slave with a three-wire interface: chip select, serial clock and serial data in, plus one data-out line with its own output enable that stands in for a tri-state pin. The array holds 2^ADDR_W words of WIDTH bits (256 x 16 by default) in internal registers. The pins are oversampled by the system clock, so the serial clock must run well below it.

A host frames each command with a 1 start bit while chip select is high. The start bit is followed by a 2-bit opcode and the word address. The block decodes six commands: read, write, single-word erase, whole-array erase, write enable and write disable. A volatile enable latch guards every command that changes the array. Program and erase operations begin on the falling edge of chip select and then run a self-timed cycle. While that cycle runs, the host polls busy or ready status on the data-out line.

Top module: `tw_eeprom`

## Requirements
- R1: After reset the enable latch is cleared, every word reads as all ones, and the data-out enable is low.
- R2: While the latch is cleared, write, erase and chip-erase frames start no cycle, show no status on the next chip-select rise, and leave the array unchanged.
- R3: A frame with opcode 00 and top two address bits 11 sets the latch, and it stays set across later commands. Opcode 00 with top address bits 00 clears the latch. The remaining address bits are don't-care but must still be clocked.
- R4: Each frame is sampled on rising serial clock as a 1 start bit, then 2 opcode bits, then ADDR_W address bits, all MSB first. Read (opcode 10) works with the latch in either state. After the last address bit, data-out drives a 0 dummy bit. Each of the next WIDTH rising edges then presents one data bit, MSB first. One further rising edge returns data-out to high-impedance.
- R5: Write (opcode 01) takes WIDTH data bits, MSB first, after the address. Its cycle starts at the chip-select fall that follows the last data bit. If chip select falls earlier, nothing changes and no cycle starts.
- R6: Erase (opcode 11) sets the addressed word to all ones. Its cycle starts at the chip-select fall that follows the last address bit. An earlier fall cancels it, and other words are untouched.
- R7: Opcode 00 with top address bits 10 sets every word to all ones at the following chip-select fall.
- R8: A cycle lasts PROG_CYCLES system clocks from the chip-select fall, within a few clocks of pin latency. While it runs, chip select high makes data-out drive 0. Once it ends, chip select high makes data-out drive 1. The status display ends at the next chip-select fall or at the next start bit.
- R9: Frames received while a cycle is running are ignored.
- R10: Data-out is high-impedance whenever chip select has been low for two system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that oversamples the pins |
| rst_ni | input | 1 | Active-low asynchronous reset, stands in for power-on |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock from the host |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out value |
| do_oe_o | output | 1 | Data-out enable; low means high-impedance |

## Verification
A stuck or wrongly set enable latch shows up at the very next chip-select rise: within about three system clocks, a status bit appears where none should, or fails to appear. A miscounted frame field shifts the dummy bit and the word on the first read, or places the high-impedance edge on the wrong serial clock. A wrong cycle length moves the first ready bit away from PROG_CYCLES after the chip-select fall. A lost or early erase is exposed by reading back both the target word and a neighbouring word.

// File: rtl/tw_eeprom_pkg.sv
package tw_eeprom_pkg;
  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } op_e;

  // sub-codes carried in the top two address bits of OP_EXT
  localparam logic [1:0] EXT_LOCK   = 2'b00;
  localparam logic [1:0] EXT_ERAALL = 2'b10;
  localparam logic [1:0] EXT_UNLOCK = 2'b11;

  typedef enum logic [1:0] {ARM_NONE, ARM_WRITE, ARM_ERASE, ARM_ALL} arm_e;

  typedef enum logic [2:0] {
    FR_IDLE, FR_HDR, FR_WDATA, FR_RDATA, FR_ARMED, FR_DONE
  } fr_e;
endpackage

// File: rtl/tw_eeprom_pins.sv
module tw_eeprom_pins (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic cs_o,
  output logic di_o,
  output logic sk_rise_o,
  output logic cs_fall_o
);
  logic cs_q, cs_qq, sk_q, sk_qq, di_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q  <= 1'b0;
      cs_qq <= 1'b0;
      sk_q  <= 1'b0;
      sk_qq <= 1'b0;
      di_q  <= 1'b0;
    end else begin
      cs_q  <= cs_i;
      cs_qq <= cs_q;
      sk_q  <= sk_i;
      sk_qq <= sk_q;
      di_q  <= di_i;
    end
  end

  assign cs_o      = cs_q;
  assign di_o      = di_q;
  assign sk_rise_o = sk_q & ~sk_qq;
  assign cs_fall_o = ~cs_q & cs_qq;
endmodule

// File: rtl/tw_eeprom_frame.sv
module tw_eeprom_frame
  import tw_eeprom_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WIDTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              sk_rise_i,
  input  logic              di_i,
  input  logic              hold_i,
  input  logic [WIDTH-1:0]  rd_word_i,
  output arm_e              arm_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WIDTH-1:0]  wdata_o,
  output logic              wen_set_o,
  output logic              wen_clr_o,
  output logic              rd_oe_o,
  output logic              rd_bit_o
);
  localparam int HDR_BITS = 2 + ADDR_W;
  localparam int CNT_MAX  = (HDR_BITS > WIDTH) ? HDR_BITS : WIDTH;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);
  localparam int POS_W    = $clog2(WIDTH + 2);

  fr_e                 state_q;
  arm_e                arm_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [HDR_BITS-1:0] hdr_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [WIDTH-1:0]    wsr_q, rsr_q;
  logic [POS_W-1:0]    rpos_q;

  logic [HDR_BITS-1:0] hdr_next;
  op_e                 op;
  logic [1:0]          ext;
  logic                active, last_hdr;

  assign hdr_next = {hdr_q[HDR_BITS-2:0], di_i};
  assign op       = op_e'(hdr_next[HDR_BITS-1 -: 2]);
  assign ext      = hdr_next[ADDR_W-1 -: 2];
  assign active   = cs_i && !hold_i && sk_rise_i;
  assign last_hdr = active && state_q == FR_HDR && cnt_q == CNT_W'(HDR_BITS - 1);

  assign wen_set_o = last_hdr && op == OP_EXT && ext == EXT_UNLOCK;
  assign wen_clr_o = last_hdr && op == OP_EXT && ext == EXT_LOCK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FR_IDLE;
      arm_q   <= ARM_NONE;
      cnt_q   <= '0;
      hdr_q   <= '0;
      addr_q  <= '0;
      wsr_q   <= '0;
      rsr_q   <= '0;
      rpos_q  <= '0;
    end else if (!cs_i || hold_i) begin
      state_q <= FR_IDLE;
      arm_q   <= ARM_NONE;
      cnt_q   <= '0;
    end else if (sk_rise_i) begin
      unique case (state_q)
        FR_IDLE: if (di_i) begin
          state_q <= FR_HDR;
          cnt_q   <= '0;
        end
        FR_HDR: begin
          hdr_q <= hdr_next;
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q == CNT_W'(HDR_BITS - 1)) begin
            cnt_q  <= '0;
            addr_q <= hdr_next[ADDR_W-1:0];
            unique case (op)
              OP_READ:  begin state_q <= FR_RDATA; rpos_q <= '0; end
              OP_WRITE: state_q <= FR_WDATA;
              OP_ERASE: begin state_q <= FR_ARMED; arm_q <= ARM_ERASE; end
              OP_EXT: begin
                if (ext == EXT_ERAALL) begin
                  state_q <= FR_ARMED;
                  arm_q   <= ARM_ALL;
                end else begin
                  state_q <= FR_DONE;
                end
              end
              default: state_q <= FR_DONE;
            endcase
          end
        end
        FR_WDATA: begin
          wsr_q <= {wsr_q[WIDTH-2:0], di_i};
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q == CNT_W'(WIDTH - 1)) begin
            state_q <= FR_ARMED;
            arm_q   <= ARM_WRITE;
          end
        end
        FR_RDATA: if (rpos_q <= POS_W'(WIDTH)) begin
          rpos_q <= rpos_q + POS_W'(1);
          // first edge after the dummy bit loads the word, later edges shift
          if (rpos_q == '0) rsr_q <= rd_word_i;
          else              rsr_q <= {rsr_q[WIDTH-2:0], 1'b0};
        end
        default: ;
      endcase
    end
  end

  assign arm_o    = (state_q == FR_ARMED) ? arm_q : ARM_NONE;
  assign addr_o   = addr_q;
  assign wdata_o  = wsr_q;
  assign rd_oe_o  = cs_i && state_q == FR_RDATA && rpos_q <= POS_W'(WIDTH);
  assign rd_bit_o = (rpos_q == '0) ? 1'b0 : rsr_q[WIDTH-1];
endmodule

// File: rtl/tw_eeprom_timer.sv
module tw_eeprom_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= CNT_W'(CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  assign busy_o = cnt_q != '0;
endmodule

// File: rtl/tw_eeprom_store.sv
module tw_eeprom_store #(
  parameter int ADDR_W = 8,
  parameter int WIDTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              clr_one_i,
  input  logic              clr_all_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o
);
  localparam int WORDS = 1 << ADDR_W;
  logic [WIDTH-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
    end else if (clr_all_i) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
    end else if (clr_one_i) begin
      mem_q[addr_i] <= '1;
    end else if (wr_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/tw_eeprom.sv
module tw_eeprom
  import tw_eeprom_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int WIDTH       = 16,
  parameter int PROG_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o,
  output logic do_oe_o
);
  logic              cs_q, di_q, sk_rise, cs_fall;
  arm_e              arm;
  logic [ADDR_W-1:0] addr;
  logic [WIDTH-1:0]  wdata, rd_word;
  logic              wen_set, wen_clr, rd_oe, rd_bit;
  logic              busy, start, wen_q, stat_q, stat_drive;

  tw_eeprom_pins u_pins (
    .clk_i, .rst_ni, .cs_i, .sk_i, .di_i,
    .cs_o(cs_q), .di_o(di_q), .sk_rise_o(sk_rise), .cs_fall_o(cs_fall)
  );

  tw_eeprom_frame #(.ADDR_W(ADDR_W), .WIDTH(WIDTH)) u_frame (
    .clk_i, .rst_ni,
    .cs_i(cs_q), .sk_rise_i(sk_rise), .di_i(di_q), .hold_i(busy),
    .rd_word_i(rd_word), .arm_o(arm), .addr_o(addr), .wdata_o(wdata),
    .wen_set_o(wen_set), .wen_clr_o(wen_clr), .rd_oe_o(rd_oe), .rd_bit_o(rd_bit)
  );

  assign start = cs_fall && arm != ARM_NONE && wen_q && !busy;

  tw_eeprom_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk_i, .rst_ni, .start_i(start), .busy_o(busy)
  );

  tw_eeprom_store #(.ADDR_W(ADDR_W), .WIDTH(WIDTH)) u_store (
    .clk_i, .rst_ni,
    .wr_i(start && arm == ARM_WRITE),
    .clr_one_i(start && arm == ARM_ERASE),
    .clr_all_i(start && arm == ARM_ALL),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rd_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wen_q <= 1'b0;
    else if (wen_set) wen_q <= 1'b1;
    else if (wen_clr) wen_q <= 1'b0;
  end

  // status stays armed until CS drops or a new start bit arrives once ready
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= 1'b0;
    else if (start) stat_q <= 1'b1;
    else if (!busy && (cs_fall || (cs_q && sk_rise && di_q))) stat_q <= 1'b0;
  end

  assign stat_drive = stat_q && cs_q;
  assign do_o       = stat_drive ? !busy : rd_bit;
  assign do_oe_o    = stat_drive || rd_oe;
endmodule

// File: rtl/tw_eeprom_checker.sv
module tw_eeprom_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_i,
  input logic do_o,
  input logic do_oe_o,
  input logic busy_i,
  input logic wen_i,
  input logic cs_q_i,
  input logic cs_fall_i,
  input logic sk_rise_i
);
  assert_cycle_needs_wen_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(wen_i));

  assert_wen_on_sk_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wen_i) |-> $past(sk_rise_i));

  assert_start_at_cs_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(cs_fall_i));

  assert_busy_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |=> busy_i);

  assert_busy_status_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && cs_q_i) |-> (do_oe_o && !do_o));

  assert_hiz_cs_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cs_i) |-> !do_oe_o);
endmodule

bind tw_eeprom tw_eeprom_checker u_chk (
  .clk_i, .rst_ni, .cs_i, .do_o, .do_oe_o,
  .busy_i(busy), .wen_i(wen_q), .cs_q_i(cs_q),
  .cs_fall_i(cs_fall), .sk_rise_i(sk_rise)
);

// File: tb/tw_eeprom_bench.sv
module tw_eeprom_bench;
  localparam int AW   = 8;
  localparam int W    = 16;
  localparam int PROG = 300;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_v, oe;
  int   total = 0, bad = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  tw_eeprom #(.ADDR_W(AW), .WIDTH(W), .PROG_CYCLES(PROG)) u_tw_eeprom (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
    .do_o(do_v), .do_oe_o(oe)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(logic b);
    di = b; idle(2); sk = 1'b1; idle(4); sk = 1'b0; idle(2);
  endtask

  task automatic send(logic [15:0] v, int n);
    for (int i = n - 1; i >= 0; i--) pulse(v[i]);
  endtask

  task automatic cs_up();   cs = 1'b1; idle(4); endtask
  task automatic cs_down(); cs = 1'b0; di = 1'b0; idle(4); endtask

  task automatic frame(logic [1:0] op, logic [7:0] a);
    pulse(1'b1); send({14'd0, op}, 2); send({8'd0, a}, 8);
  endtask

  // read frame body with CS already high; R4 layout: dummy 0, then MSB first
  task automatic read_body(logic [7:0] a, logic [15:0] exp, string req);
    logic [15:0] w;
    logic        all_oe;
    all_oe = 1'b1;
    frame(2'b10, a);
    check("R4", "dummy bit {oe,do}", {30'd0, oe, do_v}, 32'h2);
    for (int i = W - 1; i >= 0; i--) begin
      pulse(1'b0);
      w[i]   = do_v;
      all_oe = all_oe & oe;
    end
    check("R4", "oe during data", {31'd0, all_oe}, 32'h1);
    check(req, "read data", {16'd0, w}, {16'd0, exp});
    pulse(1'b0);
    check("R4", "hiz after last bit", {31'd0, oe}, 32'h0);
    cs_down();
    check("R10", "hiz with cs low", {31'd0, oe}, 32'h0);
  endtask

  task automatic expect_word(logic [7:0] a, logic [15:0] exp, string req);
    cs_up();
    read_body(a, exp, req);
  endtask

  task automatic set_wen(bit en);
    cs_up(); frame(2'b00, en ? 8'hC5 : 8'h3A); cs_down();
  endtask

  task automatic write_cmd(logic [7:0] a, logic [15:0] d, int nbits);
    cs_up(); frame(2'b01, a);
    for (int i = W - 1; i >= W - nbits; i--) pulse(d[i]);
    cs_down();
  endtask

  task automatic erase_cmd(logic [7:0] a);
    cs_up(); frame(2'b11, a); cs_down();
  endtask

  task automatic eral_cmd();
    cs_up(); frame(2'b00, 8'h80); cs_down();
  endtask

  task automatic no_status(string req);
    cs_up();
    check(req, "no status after ignored command", {31'd0, oe}, 32'h0);
    cs_down();
  endtask

  // called right after the cs_down that starts a cycle; elapsed counts from that fall
  task automatic wait_ready(string req, bit timed, bit keep_cs);
    int n;
    n = 0;
    cs_up();
    check("R8", "busy status {oe,do}", {30'd0, oe, do_v}, 32'h2);
    while (do_v !== 1'b1 && n < 4 * PROG) begin idle(1); n++; end
    check("R8", "ready status {oe,do}", {30'd0, oe, do_v}, 32'h3);
    if (timed) begin
      total++;
      if (8 + n < PROG || 8 + n > PROG + 4) begin
        bad++;
        $display("FAIL %s cycle length: actual=%0d expected=%0d..%0d", req, 8 + n, PROG, PROG + 4);
      end
    end
    if (!keep_cs) begin
      cs_down();
      check("R8", "status ends at cs fall", {31'd0, oe}, 32'h0);
    end
  endtask

  task automatic t_reset();
    check("R1", "oe after reset", {31'd0, oe}, 32'h0);
    expect_word(8'h00, 16'hFFFF, "R1");
    expect_word(8'hFF, 16'hFFFF, "R1");
  endtask

  task automatic t_locked();
    write_cmd(8'h05, 16'h1234, W); no_status("R2");
    erase_cmd(8'h05);              no_status("R2");
    eral_cmd();                    no_status("R2");
    expect_word(8'h05, 16'hFFFF, "R2");
  endtask

  task automatic t_write();
    set_wen(1'b1);
    write_cmd(8'h05, 16'h1234, W); wait_ready("R8", 1'b1, 1'b0);
    expect_word(8'h05, 16'h1234, "R5");
    write_cmd(8'hC8, 16'hA5C3, W); wait_ready("R8", 1'b1, 1'b0);
    expect_word(8'hC8, 16'hA5C3, "R5");
    expect_word(8'h05, 16'h1234, "R3");
  endtask

  task automatic t_read_locked();
    set_wen(1'b0);
    write_cmd(8'h05, 16'hAAAA, W); no_status("R3");
    expect_word(8'h05, 16'h1234, "R4");
  endtask

  task automatic t_erase();
    set_wen(1'b1);
    cs_up(); pulse(1'b1); send(16'h3, 2); send(16'h02, 7); cs_down();
    no_status("R6");
    expect_word(8'h05, 16'h1234, "R6");
    erase_cmd(8'h05); wait_ready("R6", 1'b1, 1'b0);
    expect_word(8'h05, 16'hFFFF, "R6");
    expect_word(8'hC8, 16'hA5C3, "R6");
  endtask

  task automatic t_early_write();
    write_cmd(8'h07, 16'h5A5A, 10); no_status("R5");
    expect_word(8'h07, 16'hFFFF, "R5");
  endtask

  task automatic t_busy();
    write_cmd(8'h0A, 16'h5555, W);
    cs_up();
    check("R8", "busy during frame {oe,do}", {30'd0, oe, do_v}, 32'h2);
    frame(2'b11, 8'h0A);
    cs_down();
    wait_ready("R9", 1'b0, 1'b0);
    expect_word(8'h0A, 16'h5555, "R9");
  endtask

  task automatic t_start_clears_status();
    write_cmd(8'h14, 16'h3C3C, W);
    wait_ready("R8", 1'b1, 1'b1);
    read_body(8'h14, 16'h3C3C, "R8");
  endtask

  task automatic t_eral();
    eral_cmd(); wait_ready("R7", 1'b1, 1'b0);
    expect_word(8'h0A, 16'hFFFF, "R7");
    expect_word(8'hC8, 16'hFFFF, "R7");
    expect_word(8'h14, 16'hFFFF, "R7");
  endtask

  task automatic t_lock_again();
    write_cmd(8'h03, 16'h0001, W); wait_ready("R3", 1'b0, 1'b0);
    set_wen(1'b0);
    eral_cmd(); no_status("R3");
    expect_word(8'h03, 16'h0001, "R3");
  endtask

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(5);
    t_reset();
    t_locked();
    t_write();
    t_read_locked();
    t_erase();
    t_early_write();
    t_busy();
    t_start_clears_status();
    t_eral();
    t_lock_again();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule